// File: doc/BRIEF.md
# Branch and Subroutine Next-PC Unit

This block computes the next program counter for a small processor whose instruction memory is addressed in words. On each cycle where an instruction is valid, the unit reads the current PC, the opcode class, one register value and a 16-bit displacement or target field. From these it decides whether control flow changes.

Six conditional branches test the register against zero as a signed two's complement number. A taken branch moves the PC by a sign-extended displacement counted in words. A relative subroutine call and an absolute subroutine jump both store the address of the following instruction into register 31 through a link write port. A return takes its absolute target from the register value.

All results are registered. They appear one clock after the instruction is presented, so a fetch stage can use the taken flag to flush the one instruction it fetched in the meantime.

Top module: `branch_npc_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `npc_o` is 0 and `taken_o` and `link_we_o` are 0.
- R2: Every result appears on the outputs exactly one clock after `valid_i` and the operands are sampled. With `op_i`=0 (sequential), `npc_o`=`pc_i`+1 modulo 2^PC_W and `taken_o`=0.
- R3: Op 1 (branch-if-zero) is taken when `reg_val_i` equals 0. Op 2 (branch-if-nonzero) is taken when it does not.
- R4: Op 3 (branch-if-negative) is taken when `reg_val_i` is below 0 as a signed number, including the most negative value. Op 4 (branch-if-non-negative) is taken when it is 0 or above.
- R5: Op 5 (branch-if-not-positive) is taken when `reg_val_i` is at most 0. Op 6 (branch-if-positive) is taken when it is strictly above 0.
- R6: A taken conditional branch sets `taken_o`=1 and `npc_o`=`pc_i`+sign-extended `imm_i`, modulo 2^PC_W. An untaken one gives `npc_o`=`pc_i`+1 with `taken_o`=0.
- R7: Op 7 (relative call) sets `npc_o`=`pc_i`+sign-extended `imm_i` and `taken_o`=1. It also sets `link_we_o`=1, `link_idx_o`=31 and `link_data_o`=`pc_i`+1, zero-extended.
- R8: Op 8 (absolute call) sets `npc_o`=`imm_i` zero-extended and `taken_o`=1. The link outputs are the same as for R7.
- R9: Op 9 (return) sets `npc_o`=the low PC_W bits of `reg_val_i`, `taken_o`=1 and `link_we_o`=0.
- R10: A cycle with `valid_i`=0 gives `taken_o`=0 and `link_we_o`=0 and leaves `npc_o` unchanged.
- R11: Opcodes 10 to 15 behave like op 0.
- R12: The link value is computed as `pc_i`+1 in PC_W bits. A call at the last PC therefore links to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | An instruction is present this cycle |
| op_i | input | 4 | Control-flow opcode class (0 to 9) |
| pc_i | input | PC_W (18) | Word address of the current instruction |
| reg_val_i | input | DATA_W (32) | Tested register, or the return target |
| imm_i | input | IMM_W (16) | Displacement or absolute target |
| npc_o | output | PC_W (18) | Next PC |
| taken_o | output | 1 | Control flow left the sequential path |
| link_we_o | output | 1 | Write the return address to the link register |
| link_idx_o | output | 5 | Link register index, always 31 |
| link_data_o | output | DATA_W (32) | Return address to write |

## Verification
The bench probes the zero and sign boundaries of the register test. These are 0, +1, −1 and the most negative value. A design that tested only the low bits, or compared the value as unsigned, would branch the wrong way on one of these. Negative displacements that wrap below address 0 expose a zero-extended or narrow displacement adder. A maximal 16-bit absolute target shows whether the design wrongly sign-extends the absolute field. A call at the last PC and a return value wider than the PC catch link and truncation errors. Idle cycles and unused opcodes catch a design that leaks a stale taken flag or link write.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ  = 4'd0,
        OP_BZ   = 4'd1,
        OP_BNZ  = 4'd2,
        OP_BNEG = 4'd3,
        OP_BNN  = 4'd4,
        OP_BNP  = 4'd5,
        OP_BPOS = 4'd6,
        OP_CALLR = 4'd7,
        OP_CALLA = 4'd8,
        OP_RETN = 4'd9
    } npc_op_e;

    localparam int unsigned LINK_IDX_W  = 5;
    localparam int unsigned LINK_REG_NO = 31;

endpackage

// File: rtl/npc_cond_eval.sv
module npc_cond_eval #(
    parameter int unsigned DATA_W = 32
) (
    input  npc_pkg::npc_op_e     op_i,
    input  logic [DATA_W-1:0]    val_i,
    output logic                 is_cond_o,
    output logic                 cond_hit_o
);
    import npc_pkg::*;

    logic sgn_neg;
    logic sgn_zero;
    logic sgn_pos;

    always_comb begin
        sgn_neg  = val_i[DATA_W-1];
        sgn_zero = (val_i == '0);
        sgn_pos  = !val_i[DATA_W-1] && (|val_i[DATA_W-2:0]);
    end

    // The three sign classes must partition every register value (R4, R5)
    always_comb begin
        assert_sign_partition_R4: assert ((32'(sgn_neg) + 32'(sgn_zero) + 32'(sgn_pos)) == 32'd1)
            else $error("sign classes not exclusive");
    end

    always_comb begin
        is_cond_o  = 1'b1;
        cond_hit_o = 1'b0;
        unique case (op_i)
            OP_BZ:   cond_hit_o = sgn_zero;
            OP_BNZ:  cond_hit_o = !sgn_zero;
            OP_BNEG: cond_hit_o = sgn_neg;
            OP_BNN:  cond_hit_o = !sgn_neg;
            OP_BNP:  cond_hit_o = !sgn_pos;
            OP_BPOS: cond_hit_o = sgn_pos;
            default: begin
                is_cond_o  = 1'b0;
                cond_hit_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int unsigned PC_W   = 18,
    parameter int unsigned IMM_W  = 16,
    parameter int unsigned DATA_W = 32
) (
    input  logic [PC_W-1:0]   pc_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] reg_val_i,
    output logic [PC_W-1:0]   seq_pc_o,
    output logic [PC_W-1:0]   rel_pc_o,
    output logic [PC_W-1:0]   abs_pc_o,
    output logic [PC_W-1:0]   reg_pc_o
);
    logic [PC_W-1:0] imm_sext;
    logic [PC_W-1:0] imm_zext;

    generate
        if (PC_W > IMM_W) begin : g_widen
            localparam int unsigned PAD_W = PC_W - IMM_W;
            always_comb begin
                imm_sext = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
                imm_zext = {{PAD_W{1'b0}}, imm_i};
            end
        end else begin : g_narrow
            always_comb begin
                imm_sext = imm_i[PC_W-1:0];
                imm_zext = imm_i[PC_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        seq_pc_o = pc_i + {{(PC_W-1){1'b0}}, 1'b1};
        rel_pc_o = pc_i + imm_sext;
        abs_pc_o = imm_zext;
        reg_pc_o = reg_val_i[PC_W-1:0];
    end

endmodule

// File: rtl/npc_link_gen.sv
module npc_link_gen #(
    parameter int unsigned PC_W   = 18,
    parameter int unsigned DATA_W = 32
) (
    input  logic [PC_W-1:0]   seq_pc_i,
    output logic [DATA_W-1:0] link_val_o
);
    localparam int unsigned PAD_W = DATA_W - PC_W;

    generate
        if (PAD_W > 0) begin : g_pad
            always_comb link_val_o = {{PAD_W{1'b0}}, seq_pc_i};
        end else begin : g_nopad
            always_comb link_val_o = seq_pc_i[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/branch_npc_unit.sv
module branch_npc_unit #(
    parameter int unsigned PC_W   = 18,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IMM_W  = 16
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            valid_i,
    input  logic [3:0]                      op_i,
    input  logic [PC_W-1:0]                 pc_i,
    input  logic [DATA_W-1:0]               reg_val_i,
    input  logic [IMM_W-1:0]                imm_i,
    output logic [PC_W-1:0]                 npc_o,
    output logic                            taken_o,
    output logic                            link_we_o,
    output logic [npc_pkg::LINK_IDX_W-1:0]  link_idx_o,
    output logic [DATA_W-1:0]               link_data_o
);
    import npc_pkg::*;

    typedef struct packed {
        logic [PC_W-1:0]   npc;
        logic              taken;
        logic              link_we;
        logic [DATA_W-1:0] link_data;
    } npc_state_t;

    npc_state_t state_d, state_q;
    npc_op_e    op;

    logic              is_cond, cond_hit;
    logic [PC_W-1:0]   seq_pc, rel_pc, abs_pc, reg_pc;
    logic [DATA_W-1:0] link_val;

    always_comb op = npc_op_e'(op_i);

    npc_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .op_i       (op),
        .val_i      (reg_val_i),
        .is_cond_o  (is_cond),
        .cond_hit_o (cond_hit)
    );

    npc_target_gen #(.PC_W(PC_W), .IMM_W(IMM_W), .DATA_W(DATA_W)) u_tgt (
        .pc_i      (pc_i),
        .imm_i     (imm_i),
        .reg_val_i (reg_val_i),
        .seq_pc_o  (seq_pc),
        .rel_pc_o  (rel_pc),
        .abs_pc_o  (abs_pc),
        .reg_pc_o  (reg_pc)
    );

    npc_link_gen #(.PC_W(PC_W), .DATA_W(DATA_W)) u_link (
        .seq_pc_i   (seq_pc),
        .link_val_o (link_val)
    );

    always_comb begin
        state_d           = state_q;
        state_d.taken     = 1'b0;
        state_d.link_we   = 1'b0;
        state_d.link_data = link_val;
        if (valid_i) begin
            state_d.npc = seq_pc;
            if (is_cond) begin
                if (cond_hit) begin
                    state_d.npc   = rel_pc;
                    state_d.taken = 1'b1;
                end
            end else begin
                case (op)
                    OP_CALLR: begin
                        state_d.npc     = rel_pc;
                        state_d.taken   = 1'b1;
                        state_d.link_we = 1'b1;
                    end
                    OP_CALLA: begin
                        state_d.npc     = abs_pc;
                        state_d.taken   = 1'b1;
                        state_d.link_we = 1'b1;
                    end
                    OP_RETN: begin
                        state_d.npc   = reg_pc;
                        state_d.taken = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        npc_o       = state_q.npc;
        taken_o     = state_q.taken;
        link_we_o   = state_q.link_we;
        link_data_o = state_q.link_data;
        link_idx_o  = LINK_IDX_W'(LINK_REG_NO);
    end

    assert_seq_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd0) |=> (!taken_o && npc_o == PC_W'($past(pc_i) + 1'b1)))
        else $error("sequential step wrong");

    assert_call_link_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && (op_i == 4'd7 || op_i == 4'd8)) |=>
        (link_we_o && taken_o && link_data_o[PC_W-1:0] == PC_W'($past(pc_i) + 1'b1)))
        else $error("call link wrong");

    assert_ret_target_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 4'd9) |=>
        (taken_o && !link_we_o && npc_o == $past(reg_val_i[PC_W-1:0])))
        else $error("return target wrong");

    assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!taken_o && !link_we_o && $stable(npc_o)))
        else $error("idle cycle changed state");

    assert_link_implies_taken_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        link_we_o |-> taken_o)
        else $error("link write without redirect");

endmodule

// File: tb/branch_npc_unit_tb.sv
module branch_npc_unit_tb;
    localparam int unsigned PC_W   = 18;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned IMM_W  = 16;
    localparam logic [PC_W-1:0] PC_MAX = '1;

    typedef struct {
        logic [PC_W-1:0]   npc;
        logic              taken;
        logic              we;
        logic [DATA_W-1:0] data;
        string             req;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              valid = 1'b0;
    logic [3:0]        op = '0;
    logic [PC_W-1:0]   pc = '0;
    logic [DATA_W-1:0] rv = '0;
    logic [IMM_W-1:0]  imm = '0;
    logic [PC_W-1:0]   npc;
    logic              taken, lwe;
    logic [4:0]        lidx;
    logic [DATA_W-1:0] ldata;

    int n_checks = 0;
    int n_fail   = 0;
    exp_t sb_q[$];
    logic [PC_W-1:0] model_npc = '0;

    always #4 clk = ~clk;

    branch_npc_unit #(.PC_W(PC_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .pc_i(pc),
        .reg_val_i(rv), .imm_i(imm), .npc_o(npc), .taken_o(taken),
        .link_we_o(lwe), .link_idx_o(lidx), .link_data_o(ldata)
    );

    task automatic drive(input logic v, input logic [3:0] o, input logic [PC_W-1:0] p,
                         input logic [DATA_W-1:0] r, input logic [IMM_W-1:0] i, input string req);
        exp_t e;
        logic hit;
        logic [PC_W-1:0] rel, nxt;
        int signed sv;
        @(negedge clk);
        valid = v; op = o; pc = p; rv = r; imm = i;
        sv  = $signed(r);
        nxt = p + 1;
        rel = PC_W'(int'(p) + int'($signed(i)));
        e.req = req; e.taken = 0; e.we = 0; e.data = DATA_W'(nxt);
        if (!v) begin
            e.npc = model_npc;
        end else begin
            e.npc = nxt;
            hit = 0;
            case (o)
                4'd1: hit = (sv == 0);
                4'd2: hit = (sv != 0);
                4'd3: hit = (sv < 0);
                4'd4: hit = (sv >= 0);
                4'd5: hit = (sv <= 0);
                4'd6: hit = (sv > 0);
                default: hit = 0;
            endcase
            if (hit) begin e.npc = rel; e.taken = 1; end
            if (o == 4'd7) begin e.npc = rel; e.taken = 1; e.we = 1; end
            if (o == 4'd8) begin e.npc = PC_W'(i); e.taken = 1; e.we = 1; end
            if (o == 4'd9) begin e.npc = r[PC_W-1:0]; e.taken = 1; end
        end
        model_npc = e.npc;
        sb_q.push_back(e);
    endtask

    // monitor: each pushed item is registered at the next rising edge
    always @(posedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            #2;
            n_checks++;
            if (npc !== e.npc || taken !== e.taken || lwe !== e.we ||
                (e.we && (ldata !== e.data || lidx !== 5'd31))) begin
                n_fail++;
                $display("FAIL %s: npc=%h taken=%b we=%b idx=%0d data=%h expected npc=%h taken=%b we=%b idx=31 data=%h",
                         e.req, npc, taken, lwe, lidx, ldata, e.npc, e.taken, e.we, e.data);
            end
        end
    end

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        n_checks++;
        if (npc !== '0 || taken !== 1'b0 || lwe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: npc=%h taken=%b we=%b expected 0 0 0", npc, taken, lwe);
        end
        rst_n = 1'b1;
        // R1: first cycle out of reset idle keeps reset values
        drive(0, 4'd0, 18'h0, 0, 0, "R1 after reset");
        // R2 sequential
        drive(1, 4'd0, 18'd5, 32'd9, 16'd40, "R2 seq");
        drive(1, 4'd0, PC_MAX, 0, 0, "R2 seq wrap");
        // R3
        drive(1, 4'd1, 18'd100, 32'd0, 16'd10, "R3 bz taken");
        drive(1, 4'd1, 18'd100, 32'h100, 16'd10, "R3 bz not");
        drive(1, 4'd2, 18'd200, 32'd0, 16'd4, "R3 bnz not");
        drive(1, 4'd2, 18'd200, 32'hFFFF_FFFF, 16'd4, "R3 bnz taken");
        // R4
        drive(1, 4'd3, 18'd50, 32'h8000_0000, 16'd3, "R4 bneg minint");
        drive(1, 4'd3, 18'd50, 32'd0, 16'd3, "R4 bneg zero");
        drive(1, 4'd4, 18'd50, 32'd0, 16'd3, "R4 bnn zero");
        drive(1, 4'd4, 18'd50, 32'hFFFF_FFFB, 16'd3, "R4 bnn neg");
        drive(1, 4'd4, 18'd50, 32'h7FFF_FFFF, 16'd3, "R4 bnn maxpos");
        // R5
        drive(1, 4'd5, 18'd60, 32'd0, 16'd7, "R5 bnp zero");
        drive(1, 4'd5, 18'd60, 32'd1, 16'd7, "R5 bnp one");
        drive(1, 4'd6, 18'd60, 32'd1, 16'd7, "R5 bpos one");
        drive(1, 4'd6, 18'd60, 32'd0, 16'd7, "R5 bpos zero");
        drive(1, 4'd6, 18'd60, 32'hFFFF_FFFF, 16'd7, "R5 bpos minus1");
        // R6 negative displacement wrapping below 0
        drive(1, 4'd1, 18'd3, 32'd0, 16'hFFFB, "R6 back wrap");
        drive(1, 4'd2, 18'd1000, 32'd2, 16'h8000, "R6 most negative disp");
        // R7 relative call
        drive(1, 4'd7, 18'd100, 32'd0, 16'hFFEC, "R7 callr");
        // R8 absolute call, top bit of field set
        drive(1, 4'd8, 18'd100, 32'd0, 16'hFFFF, "R8 calla");
        // R9 return, register wider than PC
        drive(1, 4'd9, 18'd77, 32'hABCD_E123, 16'd0, "R9 ret");
        // R10 idle holds and clears flags
        drive(0, 4'd7, 18'd5, 32'd0, 16'd9, "R10 idle");
        drive(0, 4'd9, 18'd5, 32'd123, 16'd9, "R10 idle2");
        // R11 unused opcodes
        drive(1, 4'd12, 18'd30, 32'd0, 16'd9, "R11 op12");
        drive(1, 4'd15, 18'd31, 32'd0, 16'd9, "R11 op15");
        // R12 call at last PC links to 0
        drive(1, 4'd8, PC_MAX, 32'd0, 16'd20, "R12 link wrap");
        drive(1, 4'd7, PC_MAX, 32'd0, 16'd2, "R12 callr wrap");
        drive(0, 4'd0, 18'd0, 0, 0, "R10 drain");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule